// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shifting element of a processor datapath. It takes a 16-bit operand, a 4-bit distance and a 3-bit operation code. It returns the shifted or rotated word and a carry bit. Eight kinds of operation are available: logical and arithmetic shifts, plain rotates, and rotates through the carry flag. Each kind can go left or right.

The unit is purely combinational, so the result settles within the same cycle as its inputs. The carry flag enters on its own input. Some operations pass the carry flag through and some include it in a 17-bit ring, so the caller always writes the returned carry bit back to its flag.

Top module: `shift_rot_unit`

## Requirements
- R1: The operation code is decoded as follows. Bit 0 selects the direction (0 = left, 1 = right). Bits 2:1 select the kind (00 = logical shift, 01 = arithmetic shift, 10 = plain rotate, 11 = rotate through carry). This gives 000 logical left, 001 logical right, 010 arithmetic left, 011 arithmetic right, 100 rotate left, 101 rotate right, 110 rotate left through carry, and 111 rotate right through carry.
- R2: Logical shifts move the operand by the distance and fill the vacated positions with 0. After a nonzero left shift bit 0 is 0, and after a nonzero right shift bit 15 is 0.
- R3: An arithmetic right shift fills the vacated positions with copies of operand bit 15, so result bit 15 always equals operand bit 15.
- R4: An arithmetic left shift gives the same result and carry as a logical left shift.
- R5: A plain rotate moves the bits circularly within the 16-bit word, so no bit is lost.
- R6: A rotate through carry rotates the 17-bit ring formed by the carry input and the 16 data bits. The carry output is the bit that ends up in the carry position.
- R7: For shifts and plain rotates with a nonzero distance s, the carry output is the last bit moved past the operand edge. That is operand bit s-1 for right operations and operand bit 16-s for left operations.
- R8: When the distance is 0, the result equals the operand and the carry output equals the carry input, for every operation code.
- R9: For shifts and plain rotates with a nonzero distance, the carry input has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 16 | Data word to shift or rotate |
| amount_i | input | 4 | Distance in bit positions, 0 to 15 |
| op_i | input | 3 | Operation code (see R1) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Shifted or rotated word |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
The hardest cases to reach are the ring positions next to the carry in a rotate through carry. There, the carry input must come back into the data word at bit 16-s or s-1, and a single operand bit must leave through the carry output. Random operands rarely make both of these visible at once. For that reason the stimulus sweeps every operation at every distance with both carry values, using single-bit, all-ones and sign-bit operands, and then adds random vectors drawn from a fixed seed.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam int DATA_W = 16;
    localparam int AMT_W  = $clog2(DATA_W);

    // Operation code: bit 0 is direction, bits 2:1 are kind.
    typedef enum logic [2:0] {
        OP_SHL = 3'b000,
        OP_SHR = 3'b001,
        OP_SAL = 3'b010,
        OP_SAR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RCL = 3'b110,
        OP_RCR = 3'b111
    } op_e;

    // What feeds the bits above the data word in the right-shift frame.
    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_SIGN  = 2'd1,
        FILL_WRAP  = 2'd2,
        FILL_CARRY = 2'd3
    } fill_e;

endpackage

// File: rtl/srot_decode.sv
module srot_decode
    import srot_pkg::*;
(
    input  logic [2:0] op_i,
    output logic       right_o,
    output fill_e      fill_o
);

    always_comb begin
        right_o = op_i[0];
        unique case (op_i[2:1])
            2'b00:   fill_o = FILL_ZERO;
            2'b01:   fill_o = op_i[0] ? FILL_SIGN : FILL_ZERO; // left arithmetic == logical
            2'b10:   fill_o = FILL_WRAP;
            default: fill_o = FILL_CARRY;
        endcase
    end

endmodule

// File: rtl/srot_mirror.sv
module srot_mirror #(
    parameter int W = 16
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign d_o[i] = d_i[W-1-i];
    end

endmodule

// File: rtl/srot_log_shifter.sv
// Right shifter built as log2 stages; each stage drops the bits that no
// later stage can still reach, so the frame narrows to W+1 at the output.
module srot_log_shifter #(
    parameter int W = 16,
    parameter int A = 4,
    localparam int IN_W  = W + (1 << A),
    localparam int OUT_W = W + 1
) (
    input  logic [IN_W-1:0]  frame_i,
    input  logic [A-1:0]     amt_i,
    output logic [OUT_W-1:0] frame_o
);

    for (genvar k = 0; k <= A; k++) begin : g_lvl
        localparam int LW = W + 1 + (1 << A) - (1 << k);
        logic [LW-1:0] v;
        if (k == 0) begin : g_src
            assign v = frame_i;
        end else begin : g_step
            localparam int STEP = 1 << (k - 1);
            assign v = amt_i[k-1] ? g_lvl[k-1].v[LW-1+STEP:STEP]
                                  : g_lvl[k-1].v[LW-1:0];
        end
    end

    assign frame_o = g_lvl[A].v;

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import srot_pkg::*;
(
    input  logic [15:0] operand_i,
    input  logic [3:0]  amount_i,
    input  logic [2:0]  op_i,
    input  logic        carry_i,
    output logic [15:0] result_o,
    output logic        carry_o
);

    localparam int W     = DATA_W;
    localparam int A     = AMT_W;
    localparam int UP_W  = (1 << A) - 2;
    localparam int FR_W  = W + (1 << A);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
    } out_t;

    logic          right;
    fill_e         fill;
    logic [W-1:0]  mirrored_in;
    logic [W-1:0]  oriented;
    logic [UP_W-1:0] upper;
    logic          mid;
    logic [FR_W-1:0] frame;
    logic [W:0]    shifted;
    logic [W-1:0]  raw_back;
    out_t          out_d;

    srot_decode u_decode (
        .op_i    (op_i),
        .right_o (right),
        .fill_o  (fill)
    );

    srot_mirror #(.W(W)) u_mirror_in (
        .d_i (operand_i),
        .d_o (mirrored_in)
    );

    // Left operations are run as right operations on the bit-reversed word.
    always_comb begin
        oriented = right ? operand_i : mirrored_in;
        unique case (fill)
            FILL_ZERO: begin
                upper = '0;
                mid   = 1'b0;
            end
            FILL_SIGN: begin
                upper = {UP_W{oriented[W-1]}};
                mid   = oriented[W-1];
            end
            FILL_WRAP: begin
                upper = oriented[UP_W:1];
                mid   = oriented[0];
            end
            default: begin
                upper = oriented[UP_W-1:0];
                mid   = carry_i;
            end
        endcase
        frame = {upper, mid, oriented, 1'b0};
    end

    srot_log_shifter #(.W(W), .A(A)) u_shift (
        .frame_i (frame),
        .amt_i   (amount_i),
        .frame_o (shifted)
    );

    srot_mirror #(.W(W)) u_mirror_out (
        .d_i (shifted[W:1]),
        .d_o (raw_back)
    );

    always_comb begin
        out_d.res = right ? shifted[W:1] : raw_back;
        out_d.cy  = (amount_i == '0) ? carry_i : shifted[0];
    end

    assign result_o = out_d.res;
    assign carry_o  = out_d.cy;

    always_comb begin
        if (amount_i == '0) begin
            AST_ZERO_PASS: assert (result_o == operand_i && carry_o == carry_i) // R8
                else $error("zero distance altered data or carry");
        end
        if (op_i == OP_SAR) begin
            AST_SAR_SIGN: assert (result_o[W-1] == operand_i[W-1]) // R3
                else $error("arithmetic right lost sign");
        end
        if (op_i == OP_SHR && amount_i != '0) begin
            AST_SHR_TOP_ZERO: assert (result_o[W-1] == 1'b0) // R2
                else $error("logical right did not zero-fill");
        end
        if ((op_i == OP_SHL || op_i == OP_SAL) && amount_i != '0) begin
            AST_SHL_LOW_ZERO: assert (result_o[0] == 1'b0) // R4
                else $error("left shift did not zero-fill");
        end
        if (op_i == OP_ROL || op_i == OP_ROR) begin
            AST_ROT_KEEPS_BITS: assert ($countones(result_o) == $countones(operand_i)) // R5
                else $error("plain rotate changed bit count");
        end
        if (op_i == OP_RCL || op_i == OP_RCR) begin
            AST_RING_KEEPS_BITS: assert ($countones({carry_o, result_o})
                                         == $countones({carry_i, operand_i})) // R6
                else $error("carry rotate changed ring bit count");
        end
    end

endmodule

// File: tb/shift_rot_unit_tb.sv
module shift_rot_unit_tb;

    logic        clk = 1'b0;
    logic [15:0] operand;
    logic [3:0]  amount;
    logic [2:0]  op;
    logic        cin;
    logic [15:0] result;
    logic        cout;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;

    always #10 clk = ~clk; // 50 MHz

    shift_rot_unit u_dut (
        .operand_i (operand),
        .amount_i  (amount),
        .op_i      (op),
        .carry_i   (cin),
        .result_o  (result),
        .carry_o   (cout)
    );

    // Bit-at-a-time reference: {carry, word}
    function automatic logic [16:0] model(input logic [2:0] o, input logic [3:0] s,
                                          input logic c_in, input logic [15:0] a);
        logic [15:0] d = a;
        logic        c = c_in;
        for (int i = 0; i < int'(s); i++) begin
            case (o)
                3'b000, 3'b010: begin c = d[15]; d = {d[14:0], 1'b0}; end
                3'b001:         begin c = d[0];  d = {1'b0, d[15:1]}; end
                3'b011:         begin c = d[0];  d = {d[15], d[15:1]}; end
                3'b100:         begin c = d[15]; d = {d[14:0], d[15]}; end
                3'b101:         begin c = d[0];  d = {d[0], d[15:1]}; end
                3'b110:         {c, d} = {d, c};
                default:        {d, c} = {c, d};
            endcase
        end
        return {c, d};
    endfunction

    function automatic string tag_of(input logic [2:0] o, input logic [3:0] s);
        if (s == 0) return "R8";
        case (o)
            3'b000, 3'b001: return "R2";
            3'b011:         return "R3";
            3'b010:         return "R4";
            3'b100, 3'b101: return "R5";
            default:        return "R6";
        endcase
    endfunction

    task automatic apply(input logic [2:0] o, input logic [3:0] s,
                         input logic c_in, input logic [15:0] a);
        logic [16:0] exp;
        @(negedge clk);
        op = o; amount = s; cin = c_in; operand = a;
        #5;
        exp = model(o, s, c_in, a);
        checks++;
        if (result !== exp[15:0]) begin
            errors++;
            $display("FAIL %s op=%b amt=%0d cin=%b a=%h: result %h expected %h",
                     tag_of(o, s), o, s, c_in, a, result, exp[15:0]);
        end
        checks++;
        if (cout !== exp[16]) begin
            errors++;
            $display("FAIL %s op=%b amt=%0d cin=%b a=%h: carry %b expected %b",
                     (o[2:1] == 2'b11 || s == 0) ? tag_of(o, s) : "R7",
                     o, s, c_in, a, cout, exp[16]);
        end
    endtask

    // R9: carry input must not matter for shifts and plain rotates
    task automatic cin_blind(input logic [2:0] o, input logic [3:0] s, input logic [15:0] a);
        logic [16:0] first;
        @(negedge clk);
        op = o; amount = s; operand = a; cin = 1'b0;
        #5 first = {cout, result};
        cin = 1'b1;
        #2;
        checks++;
        if ({cout, result} !== first) begin
            errors++;
            $display("FAIL R9 op=%b amt=%0d: got %h expected %h", o, s, {cout, result}, first);
        end
    endtask

    initial begin
        logic [15:0] corners [5] = '{16'h0001, 16'h8000, 16'hFFFF, 16'h02C5, 16'h7FFE};
        void'($urandom(32'd5150));
        operand = '0; amount = '0; op = '0; cin = 1'b0;
        // Quiet state: all-zero inputs give all-zero outputs (R8)
        #5;
        checks++;
        if (result !== 16'h0 || cout !== 1'b0) begin
            errors++;
            $display("FAIL R8 idle: got %h/%b expected 0000/0", result, cout);
        end
        // R1 decode: full sweep over every code, distance and carry
        foreach (corners[ci])
            for (int o = 0; o < 8; o++)
                for (int s = 0; s < 16; s++)
                    for (int c = 0; c < 2; c++)
                        apply(3'(o), 4'(s), 1'(c), corners[ci]);
        // R7 directed: single bit leaving each edge
        apply(3'b001, 4'd1, 1'b0, 16'h0001);
        apply(3'b000, 4'd15, 1'b0, 16'h0002);
        apply(3'b111, 4'd1, 1'b1, 16'h0000); // R6 carry enters bit 15
        apply(3'b110, 4'd1, 1'b1, 16'h0000); // R6 carry enters bit 0
        for (int o = 0; o < 6; o++) begin
            cin_blind(3'(o), 4'd1, 16'hA5C3);
            cin_blind(3'(o), 4'd9, 16'h5A3C);
        end
        for (int n = 0; n < 2000; n++)
            apply(3'($urandom), 4'($urandom), 1'($urandom), 16'($urandom));
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule